// File: doc/BRIEF.md
# Fixed-Priority Bus Grant Arbiter

This block is the central arbiter of a shared parallel bus with several requesting agents. Each agent raises its need for the bus on an active-low request line, and the arbiter answers with one active-low grant line per agent. The arbiter also watches the bus framing and initiator-ready lines, both active low, so that it knows whether the bus is idle or a transfer is still running.

Grants follow a fixed priority in which the agent with the lowest index wins. An agent keeps its grant while it keeps requesting and nobody of higher priority asks. A higher-priority request can take the grant away, but only while the framing line is high. When the grant moves from one agent to another, the timing depends on the bus. On a busy bus, meaning a transfer or its last data phase is still on the wires, the old grant falls and the new one rises on the same clock. On an idle bus, one clock with no grant at all comes between the old grant and the new one. This gap lets the agent that lost its grant see the change before another agent can drive the bus. All grant lines are registered, so each decision shows one clock after the inputs it is based on.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While reset is low, and on the first clock after it, every grant_n bit is 1.
- R2: At most one grant_n bit is 0 on any clock.
- R3: If every req_n bit is 1 at a clock edge, every grant_n bit is 1 after that edge.
- R4: If no grant is held and at least one req_n bit is 0, the agent with the lowest index whose req_n is 0 is granted after that edge. The grant is bit i of grant_n at 0.
- R5: A holder whose req_n is still 0, with no lower-index req_n at 0, keeps its grant unchanged.
- R6: The grant can move on a busy bus, meaning frame_n is 0 or irdy_n is 0. If the holder has raised its req_n, or frame_n is 1 and a lower-index agent requests, the grant moves straight to the lowest-index requester at the next edge, with no gap.
- R7: The same kind of move on an idle bus, where frame_n and irdy_n are both 1, first drops every grant for exactly one clock. The lowest-index requester is granted on the clock after that.
- R8: While frame_n is 0, a holder whose req_n is still 0 keeps its grant, even when a higher-priority agent requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | NUM_AGENTS | Request lines, one per agent, active low; bit 0 has the highest priority |
| frame_n | input | 1 | Bus framing line, active low |
| irdy_n | input | 1 | Bus initiator-ready line, active low |
| grant_n | output | NUM_AGENTS | Registered grant lines, one per agent, active low |

## Verification
Every grant decision depends on the request and bus lines sampled at one rising edge, and the result is visible after that same edge. The bench therefore drives inputs on a falling edge and checks the grant on the next falling edge, one clock later. The only result that takes two clocks is the idle-bus handoff. The bench checks it twice: one clock after the stimulus it expects all grants high, and one clock later, with the inputs held, it expects the new grant. Before each stimulus, the bench sets the holder through the ports and sweeps every request pattern for every holder and every bus state. The reference for each expected grant is worked out with integer arithmetic on agent indices.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  // Kind of decision taken at a clock edge, brought out for the checker.
  typedef enum logic [2:0] {
    ARB_QUIET = 3'd0, // nobody requests: drop all
    ARB_FIRST = 3'd1, // no holder: hand to the winner
    ARB_KEEP  = 3'd2, // holder is still the winner
    ARB_GUARD = 3'd3, // holder protected while framing is active
    ARB_GAP   = 3'd4, // idle bus: insert the empty clock
    ARB_SWAP  = 3'd5  // busy bus: same-clock handover
  } arb_dec_e;
endpackage

// File: rtl/bus_arb_state.sv
module bus_arb_state (
  input  logic frame_n,
  input  logic irdy_n,
  output logic bus_idle,
  output logic framing
);
  assign bus_idle = frame_n & irdy_n;
  assign framing  = ~frame_n;
endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick #(
  parameter int NUM_AGENTS = 4
) (
  input  logic [NUM_AGENTS-1:0] req,
  output logic [NUM_AGENTS-1:0] win_oh,
  output logic                  win_vld
);
  // seen[i] is set when some agent below index i requests.
  logic [NUM_AGENTS:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_chain
    assign win_oh[i]   = req[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req[i];
  end
  assign win_vld = seen[NUM_AGENTS];
endmodule

// File: rtl/bus_arb_fsm.sv
module bus_arb_fsm
  import bus_arb_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_AGENTS-1:0] req,
  input  logic [NUM_AGENTS-1:0] win_oh,
  input  logic                  win_vld,
  input  logic                  bus_idle,
  input  logic                  framing,
  output logic [NUM_AGENTS-1:0] gnt_q,
  output arb_dec_e              dec
);
  logic holder_any;
  logic holder_req;
  logic holder_wins;

  function automatic arb_dec_e choose(input logic vld, input logic any,
                                      input logic wins, input logic hreq,
                                      input logic frm, input logic idle);
    if (!vld)             return ARB_QUIET;
    else if (!any)        return ARB_FIRST;
    else if (wins)        return ARB_KEEP;
    else if (hreq && frm) return ARB_GUARD;
    else if (idle)        return ARB_GAP;
    else                  return ARB_SWAP;
  endfunction

  assign holder_any  = |gnt_q;
  assign holder_req  = |(gnt_q & req);
  assign holder_wins = (gnt_q == win_oh);
  assign dec = choose(win_vld, holder_any, holder_wins, holder_req, framing, bus_idle);

  logic [NUM_AGENTS-1:0] gnt_d;
  always_comb begin
    unique case (dec)
      ARB_FIRST, ARB_SWAP: gnt_d = win_oh;
      ARB_KEEP, ARB_GUARD: gnt_d = gnt_q;
      default:             gnt_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
  import bus_arb_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_AGENTS-1:0] req_n,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  output logic [NUM_AGENTS-1:0] grant_n
);
  logic [NUM_AGENTS-1:0] req;
  logic [NUM_AGENTS-1:0] win_oh;
  logic                  win_vld;
  logic                  bus_idle;
  logic                  framing;
  logic [NUM_AGENTS-1:0] gnt_q;
  arb_dec_e              dec;

  assign req = ~req_n;

  bus_arb_state u_state (
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .bus_idle(bus_idle),
    .framing (framing)
  );

  bus_arb_pick #(.NUM_AGENTS(NUM_AGENTS)) u_pick (
    .req    (req),
    .win_oh (win_oh),
    .win_vld(win_vld)
  );

  bus_arb_fsm #(.NUM_AGENTS(NUM_AGENTS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .win_oh  (win_oh),
    .win_vld (win_vld),
    .bus_idle(bus_idle),
    .framing (framing),
    .gnt_q   (gnt_q),
    .dec     (dec)
  );

  assign grant_n = ~gnt_q;
endmodule

// File: rtl/bus_grant_arbiter_chk.sv
module bus_grant_arbiter_chk
  import bus_arb_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_AGENTS-1:0] req_n,
  input logic                  frame_n,
  input logic                  irdy_n,
  input logic [NUM_AGENTS-1:0] grant_n,
  input logic                  bus_idle,
  input arb_dec_e              dec
);
  logic [NUM_AGENTS-1:0] hv;
  logic [NUM_AGENTS-1:0] req_inc;
  logic [NUM_AGENTS-1:0] low_oh;
  logic [NUM_AGENTS-1:0] above;
  logic                  held;
  logic                  hreq;
  logic                  no_higher;
  logic                  any_req;

  assign hv        = ~grant_n;
  assign req_inc   = req_n + {{(NUM_AGENTS-1){1'b0}}, 1'b1};
  assign low_oh    = ~req_n & req_inc;
  assign above     = hv - {{(NUM_AGENTS-1){1'b0}}, 1'b1};
  assign held      = |hv;
  assign hreq      = |(hv & ~req_n);
  assign no_higher = ((above & ~req_n) == '0);
  assign any_req   = ~(&req_n);

  // R1
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (&grant_n) else $error("a_r1_reset_quiet");
  end

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hv));

  a_r3_drop_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> (&grant_n));

  a_r4_first_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && any_req) |=> (hv == $past(low_oh)));

  a_r5_keep_holder: assert property (@(posedge clk) disable iff (!rst_n)
    (held && hreq && no_higher) |=> $stable(grant_n));

  a_r6_busy_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !bus_idle && !hreq && any_req) |=> (hv == $past(low_oh)));

  a_r7_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (held && bus_idle) |=> ((&grant_n) || $stable(grant_n)));

  a_r7_gap_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (dec == ARB_GAP) |=> (&grant_n));

  a_r8_guard_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (held && hreq && !frame_n) |=> $stable(grant_n));

  logic unused_ok;
  assign unused_ok = irdy_n;
endmodule

bind bus_grant_arbiter bus_grant_arbiter_chk #(.NUM_AGENTS(NUM_AGENTS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_n   (req_n),
  .frame_n (frame_n),
  .irdy_n  (irdy_n),
  .grant_n (grant_n),
  .bus_idle(bus_idle),
  .dec     (dec)
);

// File: tb/bus_grant_arbiter_bench.sv
`timescale 1ns/1ps
module bus_grant_arbiter_bench;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic [N-1:0] grant_n;
  int           total = 0;
  int           bad = 0;

  always #2.5 clk = ~clk;

  bus_grant_arbiter #(.NUM_AGENTS(N)) u_bus_grant_arbiter (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_n  (req_n),
    .frame_n(frame_n),
    .irdy_n (irdy_n),
    .grant_n(grant_n)
  );

  function automatic logic [N-1:0] gvec(input int a);
    logic [N-1:0] v = '1;
    if (a >= 0) v[a] = 1'b0;
    return v;
  endfunction

  function automatic int lowest(input logic [N-1:0] rn);
    int r = -1;
    for (int i = N - 1; i >= 0; i--) if (!rn[i]) r = i;
    return r;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] exp);
    total++;
    if (grant_n !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b (req_n=%b frame_n=%b irdy_n=%b)",
               tag, grant_n, exp, req_n, frame_n, irdy_n);
    end
    total++;
    if ($countones(~grant_n) > 1) begin
      bad++;
      $display("FAIL R2 actual=%b expected=at most one low", grant_n);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '1);
    rst_n = 1'b1;
    step();
    check("R1", '1);

    for (int h = -1; h < N; h++) begin
      for (int p = 0; p < (1 << N); p++) begin
        for (int b = 0; b < 4; b++) begin
          logic [N-1:0] pat;
          int win;
          int exp;
          string tag;
          bit gap;
          pat = N'(p);
          // clear any grant
          req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
          step();
          check("R3", '1);
          if (h >= 0) begin
            req_n = gvec(h);
            step();
            check("R4", gvec(h));
          end
          req_n = pat; frame_n = b[1]; irdy_n = b[0];
          win = lowest(pat);
          gap = 1'b0;
          if (win < 0) begin
            exp = -1; tag = "R3";
          end else if (h < 0) begin
            exp = win; tag = "R4";
          end else if (h == win) begin
            exp = h; tag = "R5";
          end else if (!pat[h] && !frame_n) begin
            exp = h; tag = "R8";
          end else if (frame_n && irdy_n) begin
            exp = -1; tag = "R7"; gap = 1'b1;
          end else begin
            exp = win; tag = "R6";
          end
          step();
          check(tag, gvec(exp));
          if (gap) begin
            step();
            check("R7", gvec(win));
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule